// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block drives a bank of independent pulse-width-modulated outputs. Each channel is set up through one 32-bit control word on a plain memory-mapped write/read bus. The word holds an enable flag, an 8-bit duty count and a 13-bit prescaler. The prescaler divides the module clock into PWM ticks. A period always spans 256 ticks, and the output stays high for the first `duty` ticks of it.

Software picks the period by choosing the prescaler and picks the pulse width by choosing the duty count. A running channel holds its duty and prescaler in shadow registers. A new setting therefore replaces the old one only when a period ends, and no period is ever cut short or stretched. Clearing the enable flag stops the channel at once. It also returns the channel's counters to the start of a period.

Top module: `pwm_bank`

## Requirements
- R1: Control word fields are: bit 31 = enable, bits 23:16 = duty count, bits 12:0 = prescaler. A read returns the last value written to that channel, with bits 30:24 and 15:13 always read as 0.
- R2: Channel n's word sits at byte address n*16. Address bits 3:0 are ignored. Writes to an address whose slot index (address >> 4) is NUM_CH or more change nothing, and reads of such an address return 0.
- R3: An enabled channel repeats a period of 256*(P+1) clock cycles, where P is the prescaler field. The output is high for the first D*(P+1) cycles of each period, where D is the duty count. The first period begins in the second cycle after the cycle in which the enabling write is presented on the bus.
- R4: A duty count of 0 keeps the output low for the whole period. A duty count of 255 drives it high for 255 of every 256 ticks.
- R5: When a write clears the enable bit, the output is low from the next cycle on. A later enable starts again from the first tick of a fresh period.
- R6: Writing an all-zero word disables the channel and clears its duty and prescaler fields, which then read back as zero.
- R7: A duty or prescaler value written while the channel runs takes effect at the next period boundary. A write presented on the bus in the last cycle of a period takes effect one period later.
- R8: Each channel runs only from its own word. Writing or enabling one channel does not change another channel's output.
- R9: After reset every control word reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the channel word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Two functions can meet in one cycle: a register write and a period boundary. When they land on the same clock edge, the shadow load sees the old value, so the new setting must wait a full extra period. The bench provokes this by presenting a write in the last cycle of a period, while it captures the output cycle by cycle. It compares the whole capture against a pattern in which two old periods come before the new one. It contrasts this with a write one cycle earlier, which must take effect after a single period, and with a disable arriving mid-period, which must cut the output low on the very next cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int WORD_W    = 32;
    localparam int DUTY_W    = 8;
    localparam int SCALE_W   = 13;
    localparam int EN_BIT    = 31;
    localparam int DUTY_LSB  = 16;
    localparam int SCALE_LSB = 0;
    localparam int SLOT_BITS = 4;

    typedef struct packed {
        logic               en;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
    } chan_cfg_t;

    function automatic chan_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.en    = w[EN_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_LSB +: SCALE_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_BIT]                 = c.en;
        w[DUTY_LSB +: DUTY_W]     = c.duty;
        w[SCALE_LSB +: SCALE_W]   = c.scale;
        return w;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
    } regs_state_t;

    regs_state_t       s_d, s_q;
    logic [NUM_CH-1:0] sel;

    // slot decode: the low SLOT_BITS address bits drop out in the shift
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel[i] = ((bus_addr >> SLOT_BITS) == ADDR_W'(i));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_wr && sel[i]) begin
                s_d.cfg[i] = cfg_from_word(bus_wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                bus_rdata = word_from_cfg(s_q.cfg[i]);
            end
        end
    end

    assign cfg_o = s_q.cfg;

    // R2: a write outside the populated slots leaves every word untouched
    a_r2_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(|sel)) |=> $stable(s_q));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R6: an all-zero write clears the whole channel word
        a_r6_zero_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && sel[i] && bus_wdata == '0) |=> (s_q.cfg[i] == '0));
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    localparam logic [DUTY_W-1:0] LAST_TICK = '1;

    typedef struct packed {
        logic               run;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
        logic [SCALE_W-1:0] presc;
        logic [DUTY_W-1:0]  tick;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        tick_end;
    logic        period_end;

    assign tick_end   = (s_q.presc == s_q.scale);
    assign period_end = tick_end && (s_q.tick == LAST_TICK);

    always_comb begin
        s_d = s_q;
        if (!cfg_i.en) begin
            s_d.run   = 1'b0;
            s_d.presc = '0;
            s_d.tick  = '0;
        end else if (!s_q.run) begin
            // first enabled edge: take the settings and start tick 0
            s_d.run   = 1'b1;
            s_d.duty  = cfg_i.duty;
            s_d.scale = cfg_i.scale;
            s_d.presc = '0;
            s_d.tick  = '0;
        end else if (tick_end) begin
            s_d.presc = '0;
            s_d.tick  = s_q.tick + 1'b1;
            if (period_end) begin
                s_d.duty  = cfg_i.duty;
                s_d.scale = cfg_i.scale;
            end
        end else begin
            s_d.presc = s_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o = cfg_i.en && s_q.run && (s_q.tick < s_q.duty);

    // R5: a disabled channel has its counters parked at the period start
    a_r5_disable_resets_counters: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (!s_q.run && s_q.presc == '0 && s_q.tick == '0));

    // R3: the prescaler never runs past the active divide value
    a_r3_presc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.presc <= s_q.scale));

    // R7: shadow settings only move on a period boundary while running
    a_r7_shadow_holds_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && cfg_i.en && !period_end) |=> ($stable(s_q.duty) && $stable(s_q.scale)));

    // R4: a zero duty count never raises the output
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.duty == '0) |-> !pwm_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[i]),
            .pwm_o (pwm_o[i])
        );
    end

    // R9: all outputs low while reset is held
    a_r9_reset_outputs_low: assert property (@(posedge clk)
        !rst_n |-> (pwm_o == '0));

endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;
    localparam int MAXS   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [NUM_CH-1:0] samp [0:MAXS-1];

    pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    always #2 clk = ~clk;

    function automatic logic pat(input int i, input int duty, input int scale);
        int per;
        per = 256 * (scale + 1);
        return (i % per) < duty * (scale + 1);
    endfunction

    function automatic logic [31:0] word(input bit en, input int duty, input int scale);
        return {en, 7'b0, duty[7:0], 3'b0, scale[12:0]};
    endfunction

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // samples pwm_o once per cycle; optionally presents a write after sample wr_at
    task automatic capture(input int n, input int wr_at, input logic [ADDR_W-1:0] a,
                           input logic [31:0] d);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            samp[i] = pwm_o;
            bus_wr  = 1'b0;
            if (i == wr_at) begin
                bus_addr  = a;
                bus_wdata = d;
                bus_wr    = 1'b1;
            end
        end
        bus_wr = 1'b0;
    endtask

    task automatic check_chan(input int ch, input int n, input int offs,
                              input int d0, input int s0, input int nper0,
                              input int d1, input int s1, input string tag);
        int  bad;
        int  split;
        int  idx;
        logic e;
        logic bad_e;
        logic bad_a;
        bad   = -1;
        bad_e = 1'b0;
        bad_a = 1'b0;
        split = nper0 * 256 * (s0 + 1);
        for (int i = 0; i < n; i++) begin
            idx = i + offs;
            e = (idx < split) ? pat(idx, d0, s0) : pat(idx - split, d1, s1);
            if (samp[i][ch] !== e && bad < 0) begin
                bad   = i;
                bad_e = e;
                bad_a = samp[i][ch];
            end
        end
        checks++;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s ch%0d sample %0d actual=%b expected=%b", tag, ch, bad, bad_a, bad_e);
        end
    endtask

    task automatic check_quiet(input int ch, input int lo, input int n, input string tag);
        int bad;
        bad = -1;
        for (int i = lo; i < n; i++) begin
            if (samp[i][ch] !== 1'b0 && bad < 0) bad = i;
        end
        checks++;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s ch%0d sample %0d actual=1 expected=0", tag, ch, bad);
        end
    endtask

    task automatic read_check(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        int n;
        int duties [6];
        duties = '{0, 1, 2, 127, 254, 255};

        // R9: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (pwm_o !== '0) begin
            failures++;
            $display("FAIL R9 outputs in reset actual=%b expected=0", pwm_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) read_check(ADDR_W'(c * 16), 32'h0, "R9 word after reset");

        // R1: field layout, reserved bits read zero; R2: address bits 3:0 ignored
        bus_write(8'h3F, 32'hFFFF_FFFF);
        read_check(8'h30, 32'h80FF_1FFF, "R1 reserved bits");
        read_check(8'h37, 32'h80FF_1FFF, "R2 alias within slot");
        // R6: all-zero write disables and clears
        bus_write(8'h3A, 32'h0);
        read_check(8'h30, 32'h0, "R6 cleared word");
        capture(20, -1, '0, '0);
        check_quiet(3, 0, 20, "R6 output after zero write");

        // R2: unmapped slot ignored, reads zero
        bus_write(8'h40, word(1, 128, 0));
        read_check(8'h40, 32'h0, "R2 unmapped read");
        for (int c = 0; c < NUM_CH; c++) read_check(ADDR_W'(c * 16), 32'h0, "R2 unmapped write");
        capture(300, -1, '0, '0);
        for (int c = 0; c < NUM_CH; c++) check_quiet(c, 0, 300, "R2 unmapped write output");

        // R2: 16-byte spacing
        bus_write(8'h25, word(0, 77, 5));
        read_check(8'h20, word(0, 77, 5), "R2 slot 2 readback");
        read_check(8'h10, 32'h0, "R2 slot 1 untouched");
        read_check(8'h30, 32'h0, "R2 slot 3 untouched");
        bus_write(8'h20, 32'h0);

        // R3/R4/R8: sweep of duty and prescaler over rotating channels
        k = 0;
        for (int s = 0; s < 3; s++) begin
            for (int j = 0; j < 6; j++) begin
                int ch;
                logic [ADDR_W-1:0] a;
                ch = k % NUM_CH;
                a  = ADDR_W'(ch * 16 + (k % 16));
                n  = 256 * (s + 1) + 8;
                bus_write(a, word(1, duties[j], s));
                capture(n, -1, '0, '0);
                if (duties[j] == 0 || duties[j] == 255)
                    check_chan(ch, n, 0, duties[j], s, 1000, 0, 0, "R4 duty extreme");
                else
                    check_chan(ch, n, 0, duties[j], s, 1000, 0, 0, "R3 period and width");
                for (int c = 0; c < NUM_CH; c++)
                    if (c != ch) check_quiet(c, 0, n, "R8 idle channel");
                bus_write(a, 32'h0);
                k++;
            end
        end

        // R5: disable mid-period cuts output next cycle, re-enable restarts
        bus_write(8'h10, word(1, 200, 1));
        capture(100, 40, 8'h10, word(0, 200, 1));
        check_chan(1, 41, 0, 200, 1, 1000, 0, 0, "R5 before disable");
        check_quiet(1, 41, 100, "R5 after disable");
        read_check(8'h10, word(0, 200, 1), "R1 last written value");
        bus_write(8'h10, word(1, 200, 1));
        capture(520, -1, '0, '0);
        check_chan(1, 520, 0, 200, 1, 1000, 0, 0, "R5 restart from period start");
        bus_write(8'h10, 32'h0);

        // R7: updates while running apply at period boundaries
        bus_write(8'h30, word(1, 64, 0));
        capture(768, 100, 8'h30, word(1, 200, 0));
        check_chan(3, 768, 0, 64, 0, 1, 200, 0, "R7 mid-period duty change");
        bus_write(8'h30, 32'h0);

        bus_write(8'h30, word(1, 64, 0));
        capture(768, 254, 8'h30, word(1, 200, 0));
        check_chan(3, 768, 0, 64, 0, 1, 200, 0, "R7 write one cycle before boundary");
        bus_write(8'h30, 32'h0);

        bus_write(8'h30, word(1, 64, 0));
        capture(768, 255, 8'h30, word(1, 200, 0));
        check_chan(3, 768, 0, 64, 0, 2, 200, 0, "R7 write on boundary edge");
        bus_write(8'h30, 32'h0);

        bus_write(8'h30, word(1, 64, 0));
        capture(768, 100, 8'h30, word(1, 64, 1));
        check_chan(3, 768, 0, 64, 0, 1, 64, 1, "R7 prescaler change");
        bus_write(8'h30, 32'h0);

        // R8: two channels running together with different settings
        bus_write(8'h20, word(1, 100, 0));
        bus_write(8'h00, word(1, 30, 1));
        capture(520, -1, '0, '0);
        check_chan(0, 520, 0, 30, 1, 1000, 0, 0, "R8 channel 0 alongside 2");
        check_chan(2, 520, 1, 100, 0, 1000, 0, 0, "R8 channel 2 alongside 0");
        check_quiet(1, 0, 520, "R8 channel 1 idle");
        check_quiet(3, 0, 520, "R8 channel 3 idle");
        bus_write(8'h20, 32'h0);
        bus_write(8'h00, 32'h0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule